// File: doc/BRIEF.md
# Host Data Buffer with Direction-Aware Level Flags

This block is a word-wide circular buffer that sits between a CPU bus port and a card bus port. Both ports run on one clock. A single mode input picks the direction of transfer. In transmit mode the CPU fills the buffer and the card side drains it. In receive mode the card side fills the buffer and the CPU drains it. The port that does not belong to the current direction is ignored. The read data port always shows the oldest stored word, so a pop takes the word that is already visible in that cycle.

The block keeps a write pointer and a read pointer. Each pointer has one extra wrap bit, so the logic can tell a full buffer from an empty one. From the distance between the two pointers it derives two level flags at a 1-word and a 4-word threshold. In transmit mode the flags tell the CPU how much free space it may fill. In receive mode they tell the CPU how many words it may take. Receive mode also tracks data a block at a time: a read-ready flag rises when a whole block of the programmed size has arrived, and it sets a sticky interrupt bit. The flag drops once the CPU has taken that whole block. A push into a full buffer or a pop from an empty buffer is dropped, and it latches a sticky error bit.

Top module: `host_data_buffer`

## Requirements
- R1: While reset is asserted, `avail_1w`, `avail_4w`, `rd_ready`, `rd_ready_irq`, `err_overflow` and `err_underflow` are all 0.
- R2: Words leave in the order they entered, including across pointer wrap. The read data port shows the oldest stored word before it is popped.
- R3: In transmit mode (`mode_rx`=0), `avail_1w` is 1 exactly when free space is at least 1 word, and `avail_4w` is 1 exactly when free space is at least 4 words. Free space is depth minus occupancy. Both flags take the state produced by the clock edge that performs the push or pop.
- R4: In receive mode (`mode_rx`=1), `avail_1w` and `avail_4w` follow occupancy against the same 1-word and 4-word thresholds, with the same timing as R3.
- R5: In transmit mode the CPU side pushes and the card side pops. In receive mode the card side pushes and the CPU side pops. A push or pop request from the other port has no effect on contents, flags or error bits.
- R6: A push into a full buffer is dropped and sets `err_overflow`, which stays set.
- R7: A pop from an empty buffer is dropped and sets `err_underflow`, which stays set.
- R8: In receive mode, with `blk_words` nonzero, `rd_ready` rises on the edge at which occupancy reaches at least `blk_words`. `rd_ready_irq` is set on that same edge.
- R9: Once `rd_ready` is high, it stays high until the CPU has completed `blk_words` pops. It falls on the edge of the last of those pops.
- R10: A cycle with `stat_clr` high clears `rd_ready_irq`, `err_overflow` and `err_underflow`. If an event that sets one of these bits happens in the same cycle, the set takes priority.
- R11: In transmit mode `rd_ready` stays 0 and `rd_ready_irq` is not set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst_n | input | 1 | Synchronous reset, active low |
| mode_rx | input | 1 | 0 = transmit (CPU writes), 1 = receive (card writes) |
| blk_words | input | AW+1 | Block size in words for the read-ready flag |
| cpu_wr | input | 1 | CPU push request |
| cpu_wdata | input | DATA_W | CPU push data |
| cpu_rd | input | 1 | CPU pop request |
| cpu_rdata | output | DATA_W | Oldest stored word, as seen by the CPU |
| card_wr | input | 1 | Card-side push request |
| card_wdata | input | DATA_W | Card-side push data |
| card_rd | input | 1 | Card-side pop request |
| card_rdata | output | DATA_W | Oldest stored word, as seen by the card side |
| stat_clr | input | 1 | Clears the interrupt and error bits |
| avail_1w | output | 1 | At least 1 word of room (transmit) or of data (receive) |
| avail_4w | output | 1 | At least 4 words of room (transmit) or of data (receive) |
| rd_ready | output | 1 | A whole block is waiting for the CPU (receive only) |
| rd_ready_irq | output | 1 | Sticky bit, set when `rd_ready` rises |
| err_overflow | output | 1 | Sticky bit: a push into a full buffer was dropped |
| err_underflow | output | 1 | Sticky bit: a pop from an empty buffer was dropped |

## Verification
If one of the pointers is wrong, the level flags are wrong by the next sample after the edge that caused it. The following pop also returns a word out of sequence. Both are checked right after each edge during long fill and drain runs that wrap the pointers. If the block counter is wrong, `rd_ready` falls one pop too early or too late. So the flag is sampled after every single CPU pop of a block, not only at the end. A direction-select fault shows up as a dropped push or a spurious error bit one cycle after a request from the wrong port.

// File: rtl/hdb_pkg.sv
// Shared types for the host data buffer.
// Assumes: a single transfer direction is active at a time.
package hdb_pkg;

    // Which side fills the buffer.
    typedef enum logic {
        XFER_TX = 1'b0,   // CPU pushes, card side pops
        XFER_RX = 1'b1    // card side pushes, CPU pops
    } xfer_dir_e;

endpackage

// File: rtl/hdb_ptr.sv
// Circular buffer pointer with one extra wrap bit.
// Assumes: the depth is 2**AW, so natural binary wrap is correct.
module hdb_ptr #(
    parameter int AW = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        inc,
    output logic [AW:0] ptr_o
);

    logic [AW:0] ptr_q;

    // Advance the pointer on each accepted operation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
        end else if (inc) begin
            ptr_q <= ptr_q + 1'b1;
        end
    end

    assign ptr_o = ptr_q;

endmodule

// File: rtl/hdb_mem.sv
// Word storage: one write port and one combinational read port.
// Assumes: the caller never writes a full buffer. The contents are not reset.
module hdb_mem #(
    parameter int DW = 32,
    parameter int AW = 7,
    localparam int DEPTH = 1 << AW
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [DW-1:0] wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [DW-1:0] rd_data
);

    logic [DW-1:0] mem_q [DEPTH];

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[wr_addr] <= wr_data;
        end
    end

    // Show the word at the read pointer.
    assign rd_data = mem_q[rd_addr];

endmodule

// File: rtl/hdb_flags.sv
// Level flags at two thresholds. The measure is free space in transmit
// and occupancy in receive.
// Assumes: occ_nxt is the occupancy after this cycle's operations, so the
// registered flags match the pointers as updated on the same edge.
module hdb_flags
    import hdb_pkg::*;
#(
    parameter int AW     = 7,
    parameter int TH_LO  = 1,
    parameter int TH_HI  = 4
) (
    input  logic        clk,
    input  logic        rst_n,
    input  xfer_dir_e   dir,
    input  logic [AW:0] occ_nxt,
    output logic        lvl_lo,
    output logic        lvl_hi
);

    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};
    localparam logic [AW:0] TH_LO_V = (AW+1)'(TH_LO);
    localparam logic [AW:0] TH_HI_V = (AW+1)'(TH_HI);

    logic [AW:0] measure;
    logic        lo_q;
    logic        hi_q;

    // Choose between room and data by direction.
    assign measure = (dir == XFER_RX) ? occ_nxt : (DEPTH_V - occ_nxt);

    // Register the threshold comparisons.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lo_q <= 1'b0;
            hi_q <= 1'b0;
        end else begin
            lo_q <= (measure >= TH_LO_V);
            hi_q <= (measure >= TH_HI_V);
        end
    end

    assign lvl_lo = lo_q;
    assign lvl_hi = hi_q;

    // R3: the higher threshold can only be met if the lower one is met.
    a_r3_lvl_nested: assert property (@(posedge clk) disable iff (!rst_n)
        lvl_hi |-> lvl_lo);

endmodule

// File: rtl/hdb_blk.sv
// Block read-ready tracker for receive mode, with its sticky interrupt bit.
// Assumes: blk_words stays constant while a block is being read out.
module hdb_blk
    import hdb_pkg::*;
#(
    parameter int AW = 7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  xfer_dir_e   dir,
    input  logic [AW:0] occ_nxt,
    input  logic [AW:0] blk_words,
    input  logic        cpu_pop,
    input  logic        stat_clr,
    output logic        rdy_o,
    output logic        irq_o
);

    logic        rdy_q;
    logic        irq_q;
    logic [AW:0] cnt_q;
    logic        arm;
    logic        done;

    // A block has arrived and nothing is being tracked yet.
    assign arm  = (dir == XFER_RX) && !rdy_q && (blk_words != '0)
                  && (occ_nxt >= blk_words);
    // The CPU is taking the last word of the tracked block.
    assign done = rdy_q && cpu_pop && ((cnt_q + 1'b1) >= blk_words);

    // Track the ready flag and count the CPU pops within the block.
    always_ff @(posedge clk) begin
        if (!rst_n || dir == XFER_TX) begin
            rdy_q <= 1'b0;
            cnt_q <= '0;
        end else if (done) begin
            rdy_q <= 1'b0;
            cnt_q <= '0;
        end else if (rdy_q) begin
            if (cpu_pop) begin
                cnt_q <= cnt_q + 1'b1;
            end
        end else if (arm) begin
            rdy_q <= 1'b1;
            cnt_q <= '0;
        end
    end

    // Sticky interrupt bit: a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
        end else if (arm) begin
            irq_q <= 1'b1;
        end else if (stat_clr) begin
            irq_q <= 1'b0;
        end
    end

    assign rdy_o = rdy_q;
    assign irq_o = irq_q;

    // R8: each rising edge of the ready flag comes with the interrupt bit.
    a_r8_irq_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rdy_o) |-> irq_o);

    // R11: the ready flag stays low while transmit is selected.
    a_r11_no_rdy_tx: assert property (@(posedge clk) disable iff (!rst_n)
        (dir == XFER_TX && $past(dir) == XFER_TX) |-> !rdy_o);

endmodule

// File: rtl/host_data_buffer.sv
// Host data buffer: a direction-switched circular buffer with level flags,
// block read-ready tracking and sticky error bits.
// Assumes: DEPTH is a power of two of at least 4, and mode_rx changes only
// while the buffer is empty.
module host_data_buffer
    import hdb_pkg::*;
#(
    parameter  int DEPTH  = 128,
    parameter  int DATA_W = 32,
    localparam int AW     = $clog2(DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mode_rx,
    input  logic [AW:0]       blk_words,
    input  logic              cpu_wr,
    input  logic [DATA_W-1:0] cpu_wdata,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic              card_wr,
    input  logic [DATA_W-1:0] card_wdata,
    input  logic              card_rd,
    output logic [DATA_W-1:0] card_rdata,
    input  logic              stat_clr,
    output logic              avail_1w,
    output logic              avail_4w,
    output logic              rd_ready,
    output logic              rd_ready_irq,
    output logic              err_overflow,
    output logic              err_underflow
);

    localparam logic [AW:0] DEPTH_V = {1'b1, {AW{1'b0}}};

    xfer_dir_e         dir;
    logic              push_req;
    logic              pop_req;
    logic [DATA_W-1:0] push_data;
    logic [DATA_W-1:0] rd_data;
    logic [AW:0]       wptr;
    logic [AW:0]       rptr;
    logic [AW:0]       occ;
    logic [AW:0]       occ_nxt;
    logic              full;
    logic              empty;
    logic              push_ok;
    logic              pop_ok;
    logic              ovf_q;
    logic              udf_q;

    // Decode the direction and route the active ports.
    assign dir       = mode_rx ? XFER_RX : XFER_TX;
    assign push_req  = (dir == XFER_RX) ? card_wr    : cpu_wr;
    assign pop_req   = (dir == XFER_RX) ? cpu_rd     : card_rd;
    assign push_data = (dir == XFER_RX) ? card_wdata : cpu_wdata;

    // Occupancy and its state after this cycle's accepted operations.
    assign occ     = wptr - rptr;
    assign full    = (occ == DEPTH_V);
    assign empty   = (occ == '0);
    assign push_ok = push_req && !full;
    assign pop_ok  = pop_req && !empty;
    assign occ_nxt = occ + {{AW{1'b0}}, push_ok} - {{AW{1'b0}}, pop_ok};

    hdb_ptr #(.AW(AW)) u_wptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (push_ok),
        .ptr_o (wptr)
    );

    hdb_ptr #(.AW(AW)) u_rptr (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (pop_ok),
        .ptr_o (rptr)
    );

    hdb_mem #(.DW(DATA_W), .AW(AW)) u_mem (
        .clk     (clk),
        .wr_en   (push_ok),
        .wr_addr (wptr[AW-1:0]),
        .wr_data (push_data),
        .rd_addr (rptr[AW-1:0]),
        .rd_data (rd_data)
    );

    hdb_flags #(.AW(AW), .TH_LO(1), .TH_HI(4)) u_flags (
        .clk     (clk),
        .rst_n   (rst_n),
        .dir     (dir),
        .occ_nxt (occ_nxt),
        .lvl_lo  (avail_1w),
        .lvl_hi  (avail_4w)
    );

    hdb_blk #(.AW(AW)) u_blk (
        .clk       (clk),
        .rst_n     (rst_n),
        .dir       (dir),
        .occ_nxt   (occ_nxt),
        .blk_words (blk_words),
        .cpu_pop   (pop_ok && dir == XFER_RX),
        .stat_clr  (stat_clr),
        .rdy_o     (rd_ready),
        .irq_o     (rd_ready_irq)
    );

    // Sticky error bits: a set in the same cycle beats a clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf_q <= 1'b0;
            udf_q <= 1'b0;
        end else begin
            if (push_req && full)       ovf_q <= 1'b1;
            else if (stat_clr)          ovf_q <= 1'b0;
            if (pop_req && empty)       udf_q <= 1'b1;
            else if (stat_clr)          udf_q <= 1'b0;
        end
    end

    assign err_overflow  = ovf_q;
    assign err_underflow = udf_q;
    assign cpu_rdata     = rd_data;
    assign card_rdata    = rd_data;

    // R6: the two pointers never drift further apart than the depth.
    a_r6_occ_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= DEPTH_V);

    // R6: a push into a full buffer is reported on the next cycle.
    a_r6_ovf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (push_req && full) |=> err_overflow);

    // R7: a pop from an empty buffer is reported on the next cycle.
    a_r7_udf_flag: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_req && empty) |=> err_underflow);

endmodule

// File: tb/host_data_buffer_bench.sv
module host_data_buffer_bench;

    localparam int DEPTH = 128;
    localparam int DW    = 32;
    localparam int AW    = $clog2(DEPTH);

    logic          clk = 1'b0;
    logic          rst_n;
    logic          mode_rx;
    logic [AW:0]   blk_words;
    logic          cpu_wr, cpu_rd, card_wr, card_rd, stat_clr;
    logic [DW-1:0] cpu_wdata, card_wdata;
    logic [DW-1:0] cpu_rdata, card_rdata;
    logic          avail_1w, avail_4w, rd_ready, rd_ready_irq;
    logic          err_overflow, err_underflow;

    int n_checks = 0;
    int n_errors = 0;

    always #5 clk = ~clk;

    host_data_buffer #(.DEPTH(DEPTH), .DATA_W(DW)) u_host_data_buffer (
        .clk(clk), .rst_n(rst_n), .mode_rx(mode_rx), .blk_words(blk_words),
        .cpu_wr(cpu_wr), .cpu_wdata(cpu_wdata), .cpu_rd(cpu_rd),
        .cpu_rdata(cpu_rdata), .card_wr(card_wr), .card_wdata(card_wdata),
        .card_rd(card_rd), .card_rdata(card_rdata), .stat_clr(stat_clr),
        .avail_1w(avail_1w), .avail_4w(avail_4w), .rd_ready(rd_ready),
        .rd_ready_irq(rd_ready_irq), .err_overflow(err_overflow),
        .err_underflow(err_underflow)
    );

    task automatic chk(input string tag, input logic [DW-1:0] got,
                       input logic [DW-1:0] exp);
        n_checks++;
        if (got !== exp) begin
            n_errors++;
            $display("FAIL %s: got %h expected %h", tag, got, exp);
        end
    endtask

    // One clock edge; inputs change and outputs are sampled at the negedge.
    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle();
        cpu_wr = 0; cpu_rd = 0; card_wr = 0; card_rd = 0; stat_clr = 0;
    endtask

    task automatic t_reset();
        rst_n = 0; mode_rx = 0; blk_words = 8; idle();
        cpu_wdata = '0; card_wdata = '0;
        repeat (3) step();
        chk("R1 flags in reset", {avail_1w, avail_4w, rd_ready}, 0);
        chk("R1 irq/err in reset", {rd_ready_irq, err_overflow, err_underflow}, 0);
        rst_n = 1;
        step();
        chk("R3 empty tx flags", {avail_1w, avail_4w}, 2'b11);
    endtask

    task automatic t_tx_fill();
        for (int i = 0; i < 124; i++) begin
            cpu_wr = 1; cpu_wdata = 32'hA000_0000 + i; step();
        end
        idle();
        chk("R3 free 4", {avail_1w, avail_4w}, 2'b11);
        cpu_wr = 1; cpu_wdata = 32'hA000_0000 + 124; step(); idle();
        chk("R3 free 3", {avail_1w, avail_4w}, 2'b10);
        for (int i = 125; i < 128; i++) begin
            cpu_wr = 1; cpu_wdata = 32'hA000_0000 + i; step();
        end
        idle();
        chk("R3 full", {avail_1w, avail_4w}, 2'b00);
        cpu_wr = 1; cpu_wdata = 32'hDEAD_BEEF; step(); idle();
        chk("R6 overflow bit", err_overflow, 1);
        chk("R6 still full", avail_1w, 0);
        chk("R11 no ready in tx", {rd_ready, rd_ready_irq}, 0);
    endtask

    task automatic t_tx_drain();
        int bad = 0;
        for (int i = 0; i < 128; i++) begin
            if (card_rdata !== 32'hA000_0000 + i) bad++;
            card_rd = 1; step();
        end
        idle();
        chk("R2 tx order mismatches", bad, 0);
        chk("R3 drained tx flags", {avail_1w, avail_4w}, 2'b11);
        chk("R6 overflow sticky", err_overflow, 1);
    endtask

    task automatic t_wrong_side();
        cpu_rd = 1; step(); idle();
        chk("R5 cpu pop ignored in tx", err_underflow, 0);
        card_wr = 1; card_wdata = 32'h1234_5678; step(); idle();
        card_rd = 1; step(); idle();
        chk("R5 card push ignored in tx", err_underflow, 1);
        stat_clr = 1; step(); idle();
        chk("R10 clear errors", {err_overflow, err_underflow}, 0);
    endtask

    task automatic t_rx_block();
        int bad = 0;
        mode_rx = 1; step();
        chk("R4 empty rx flags", {avail_1w, avail_4w}, 2'b00);
        cpu_wr = 1; cpu_wdata = 32'h5555_5555; step(); idle();
        chk("R5 cpu push ignored in rx", avail_1w, 0);
        for (int i = 0; i < 3; i++) begin
            card_wr = 1; card_wdata = 32'hB000_0000 + i; step();
        end
        idle();
        chk("R4 three words", {avail_1w, avail_4w}, 2'b10);
        card_wr = 1; card_wdata = 32'hB000_0003; step(); idle();
        chk("R4 four words", {avail_1w, avail_4w}, 2'b11);
        for (int i = 4; i < 7; i++) begin
            card_wr = 1; card_wdata = 32'hB000_0000 + i; step();
        end
        idle();
        chk("R8 not ready at 7", rd_ready, 0);
        card_wr = 1; card_wdata = 32'hB000_0007; step(); idle();
        chk("R8 ready at 8", rd_ready, 1);
        chk("R8 irq with ready", rd_ready_irq, 1);
        for (int i = 0; i < 7; i++) begin
            if (cpu_rdata !== 32'hB000_0000 + i) bad++;
            cpu_rd = 1; step(); idle();
            if (rd_ready !== 1'b1) bad++;
        end
        chk("R9 held and ordered over 7 pops", bad, 0);
        chk("R2 last rx word", cpu_rdata, 32'hB000_0007);
        cpu_rd = 1; step(); idle();
        chk("R9 drop after 8th pop", rd_ready, 0);
        chk("R10 irq sticky", rd_ready_irq, 1);
        stat_clr = 1; step(); idle();
        chk("R10 irq cleared", rd_ready_irq, 0);
        cpu_rd = 1; step(); idle();
        chk("R7 rx underflow", err_underflow, 1);
        chk("R7 still empty", avail_1w, 0);
    endtask

    initial begin
        #(200000 * 10);
        n_checks++; n_errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

    initial begin
        t_reset();
        t_tx_fill();
        t_tx_drain();
        t_wrong_side();
        t_rx_block();
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    end

endmodule